// File: doc/BRIEF.md
# Multiplexed Sample/Hold Refresh Sequencer

This controller keeps a bank of analog sample/hold channels charged from a single shared DAC. The bank is made of several multiplexers, each with a fixed number of channels. One channel address is shared by all multiplexers, and each multiplexer has its own active-low mode line. The sequencer visits every output channel in turn. For each one it fetches the channel's code over a request/valid port and loads it into the DAC. It then sets the channel address and pulls exactly one mode line low for the acquisition time, and finally lets the line return high.

All analog timing limits are given in nanoseconds as parameters and converted to clock cycles, rounding up. These limits are the address setup before sampling, the address hold after sampling, the all-lines-high inhibit window, the minimum sample time and the refresh period. A full pass is restarted once per refresh period for as long as the enable input stays high.

Top module: `shmux_refresh_seq`

## Requirements
- R1: After reset every bit of `mode_n` is 1, `ch_addr` is 0, and `busy`, `code_req` and `dac_load` are 0. No request is issued while `enable` stays low.
- R2: Each pass visits channels 0 to NUM_MUX*CH_PER_MUX-1 in ascending order. For channel c, bit c/CH_PER_MUX of `mode_n` goes low and `ch_addr` equals c mod CH_PER_MUX.
- R3: While waiting for a code, `code_req` is high and `code_idx` is the channel number. In the cycle where `code_valid` is seen high, `code_data` is latched to `dac_code`, and `dac_load` pulses high for one cycle in the next cycle. Exactly one load occurs before each sample, and it carries that channel's code.
- R4: While `code_req` is high and `code_valid` is low, all mode lines stay high and `code_idx` keeps the pending channel. A stalled channel is never skipped.
- R5: At most one bit of `mode_n` is low in any cycle.
- R6: Each low pulse on a mode line lasts exactly SAMP_CYC = ceil(SAMPLE_NS*CLK_HZ/1e9) cycles.
- R7: `ch_addr` has been unchanged for at least SETUP_CYC cycles before a mode line falls.
- R8: `ch_addr` changes only while all mode lines are high, and only after at least HOLD_CYC all-high cycles that follow the last sample.
- R9: Before every sample, all mode lines have been high for at least INHIBIT_CYC cycles.
- R10: A pass starts (its first `code_req` for channel 0) REFRESH_CYC cycles after the previous start. If the previous pass overruns that time, the next pass starts in the cycle after the last channel's hold window.
- R11: When `enable` drops, the pass in progress completes all channels. No further pass starts, and `busy` ends low.
- R12: `busy` is high whenever a code request or a sample is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run periodic refresh passes |
| code_req | output | 1 | Code wanted for channel `code_idx` |
| code_idx | output | $clog2(NUM_MUX*CH_PER_MUX) | Channel whose code is requested |
| code_valid | input | 1 | `code_data` is valid |
| code_data | input | CODE_W | Code for the requested channel |
| dac_load | output | 1 | One-cycle DAC load strobe |
| dac_code | output | CODE_W | Code presented to the DAC |
| ch_addr | output | $clog2(CH_PER_MUX) | Channel address shared by all multiplexers |
| mode_n | output | NUM_MUX | Per-multiplexer mode line, 0 = sample, 1 = hold |
| busy | output | 1 | Pass in progress |

## Verification
The bench keeps the default 4 x 8 bank and a 125 MHz clock, but it shortens the timing parameters. It uses 40 ns for the sample time, 20 ns for setup, 30 ns for hold and 50 ns for the inhibit window, which gives 5, 3, 4 and 7 cycles. The refresh period is set to 8000 ns, which is 1000 cycles. With these values every one of the 32 channels is sampled on all four mode lines across several complete passes within a few thousand cycles. Varying code stalls make one pass finish on time and force another to overrun the period, so both start rules are reached.

// File: rtl/shmux_pkg.sv
package shmux_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_SAMP,
    ST_POST,
    ST_WAIT
  } seq_state_t;

  // Convert a duration in ns to clock cycles, rounding up, minimum one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned hz);
    longint unsigned prod;
    longint unsigned q;
    prod = longint'(ns) * longint'(hz);
    q    = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (q == 64'd0) q = 64'd1;
    return q[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/shmux_timer.sv
module shmux_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/shmux_period.sv
module shmux_period #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);
  logic [W-1:0] cnt;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + W'(1);
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/shmux_mode_dec.sv
module shmux_mode_dec #(
  parameter int unsigned NUM_MUX = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_MUX-1:0] mode_n
);
  for (genvar i = 0; i < NUM_MUX; i++) begin : g_line
    assign mode_n[i] = ~(en && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/shmux_refresh_seq.sv
module shmux_refresh_seq
  import shmux_pkg::*;
#(
  parameter int unsigned NUM_MUX    = 4,
  parameter int unsigned CH_PER_MUX = 8,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned SAMPLE_NS  = 4000,
  parameter int unsigned SETUP_NS   = 50,
  parameter int unsigned HOLD_NS    = 150,
  parameter int unsigned INHIBIT_NS = 200,
  parameter int unsigned REFRESH_NS = 100_000_000,
  localparam int unsigned ADDR_W = $clog2(CH_PER_MUX),
  localparam int unsigned CH_W   = $clog2(NUM_MUX * CH_PER_MUX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic              code_req,
  output logic [CH_W-1:0]   code_idx,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_data,
  output logic              dac_load,
  output logic [CODE_W-1:0] dac_code,
  output logic [ADDR_W-1:0] ch_addr,
  output logic [NUM_MUX-1:0] mode_n,
  output logic              busy
);
  localparam int unsigned SEL_W       = CH_W - ADDR_W;
  localparam int unsigned NUM_CH      = NUM_MUX * CH_PER_MUX;
  localparam int unsigned SAMP_CYC    = ns_to_cyc(SAMPLE_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC   = ns_to_cyc(SETUP_NS, CLK_HZ);
  localparam int unsigned HOLD_CYC    = ns_to_cyc(HOLD_NS, CLK_HZ);
  localparam int unsigned INHIBIT_CYC = ns_to_cyc(INHIBIT_NS, CLK_HZ);
  localparam int unsigned REFRESH_CYC = ns_to_cyc(REFRESH_NS, CLK_HZ);
  localparam int unsigned PRE_CYC     = max2(SETUP_CYC, INHIBIT_CYC);
  localparam int unsigned TMR_MAX     = max2(max2(PRE_CYC, SAMP_CYC), HOLD_CYC);
  localparam int unsigned TMR_W       = $clog2(TMR_MAX + 1);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_t       state;
  logic [CH_W-1:0]  chan;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;
  logic             per_clear;
  logic             per_expired;

  // Named events for the checker and for readability.
  logic code_accept;
  logic sample_fall;
  logic sample_rise;
  logic hold_over;
  logic pass_start;

  assign code_accept = (state == ST_REQ)  && code_valid;
  assign sample_fall = (state == ST_PRE)  && tmr_done;
  assign sample_rise = (state == ST_SAMP) && tmr_done;
  assign hold_over   = (state == ST_POST) && tmr_done;
  assign pass_start  = ((state == ST_IDLE) && enable) ||
                       ((state == ST_WAIT) && enable && per_expired);

  assign tmr_load  = code_accept || sample_fall || sample_rise;
  always_comb begin
    tmr_val = TMR_W'(HOLD_CYC - 1);
    if (code_accept)      tmr_val = TMR_W'(PRE_CYC - 1);
    else if (sample_fall) tmr_val = TMR_W'(SAMP_CYC - 1);
  end
  assign per_clear = pass_start;

  shmux_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  shmux_period #(.LIMIT(REFRESH_CYC)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (per_clear),
    .expired (per_expired)
  );

  shmux_mode_dec #(.NUM_MUX(NUM_MUX), .SEL_W(SEL_W)) u_dec (
    .en     (state == ST_SAMP),
    .sel    (chan[CH_W-1 -: SEL_W]),
    .mode_n (mode_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      chan  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (pass_start) begin
          state <= ST_REQ;
          chan  <= '0;
        end
        ST_REQ:  if (code_accept) state <= ST_PRE;
        ST_PRE:  if (sample_fall) state <= ST_SAMP;
        ST_SAMP: if (sample_rise) state <= ST_POST;
        ST_POST: if (hold_over) begin
          if (chan == LAST_CH) state <= ST_WAIT;
          else begin
            state <= ST_REQ;
            chan  <= chan + CH_W'(1);
          end
        end
        ST_WAIT: begin
          if (!enable) state <= ST_IDLE;
          else if (pass_start) begin
            state <= ST_REQ;
            chan  <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0;
      dac_load <= 1'b0;
      ch_addr  <= '0;
    end else begin
      dac_load <= code_accept;
      if (code_accept) begin
        dac_code <= code_data;
        ch_addr  <= chan[ADDR_W-1:0];
      end
    end
  end

  assign code_req = (state == ST_REQ);
  assign code_idx = chan;
  assign busy     = (state == ST_REQ) || (state == ST_PRE) ||
                    (state == ST_SAMP) || (state == ST_POST);
endmodule

// File: rtl/shmux_refresh_chk.sv
module shmux_refresh_chk
  import shmux_pkg::*;
#(
  parameter int unsigned NUM_MUX    = 4,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned SAMPLE_NS  = 4000,
  parameter int unsigned SETUP_NS   = 50,
  parameter int unsigned HOLD_NS    = 150,
  parameter int unsigned INHIBIT_NS = 200
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_MUX-1:0] mode_n,
  input logic [ADDR_W-1:0]  ch_addr,
  input logic               code_req,
  input logic               code_valid,
  input logic               dac_load,
  input logic               busy,
  input logic               sample_fall
);
  localparam int unsigned SAMP_CYC    = ns_to_cyc(SAMPLE_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC   = ns_to_cyc(SETUP_NS, CLK_HZ);
  localparam int unsigned HOLD_CYC    = ns_to_cyc(HOLD_NS, CLK_HZ);
  localparam int unsigned INHIBIT_CYC = ns_to_cyc(INHIBIT_NS, CLK_HZ);

  logic        all_hi;
  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;
  logic [31:0] addr_age;
  logic [ADDR_W-1:0] addr_prev;

  assign all_hi = &mode_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      addr_age  <= '0;
      addr_prev <= '0;
    end else begin
      hi_cnt    <= all_hi ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 32'd1) : '0;
      lo_cnt    <= all_hi ? '0 : lo_cnt + 32'd1;
      addr_age  <= (ch_addr == addr_prev) ? ((addr_age == '1) ? addr_age : addr_age + 32'd1) : 32'd1;
      addr_prev <= ch_addr;
    end
  end

  // R5
  single_mux_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mode_n));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_addr != $past(ch_addr)) |-> (all_hi && hi_cnt >= HOLD_CYC));

  // R6
  sample_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_hi) |-> (lo_cnt == SAMP_CYC));

  // R7
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_hi) |-> (addr_age >= SETUP_CYC));

  // R9
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_hi) |-> (hi_cnt >= INHIBIT_CYC));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_req && !code_valid) |-> all_hi);

  // R3
  load_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> $past(code_req && code_valid));

  // R12
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_req || !all_hi) |-> busy);

  // R7
  fall_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fall |=> !all_hi);
endmodule

bind shmux_refresh_seq shmux_refresh_chk #(
  .NUM_MUX    (NUM_MUX),
  .ADDR_W     (ADDR_W),
  .CLK_HZ     (CLK_HZ),
  .SAMPLE_NS  (SAMPLE_NS),
  .SETUP_NS   (SETUP_NS),
  .HOLD_NS    (HOLD_NS),
  .INHIBIT_NS (INHIBIT_NS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_n      (mode_n),
  .ch_addr     (ch_addr),
  .code_req    (code_req),
  .code_valid  (code_valid),
  .dac_load    (dac_load),
  .busy        (busy),
  .sample_fall (sample_fall)
);

// File: tb/shmux_refresh_seq_tb.sv
module shmux_refresh_seq_tb_top;
  // 125 MHz clock, 8 ns period: cycles = ceil(ns / 8)
  localparam int SAMPLE_NS = 40, SETUP_NS = 20, HOLD_NS = 30, INHIBIT_NS = 50, REFRESH_NS = 8000;
  localparam int NCH = 32;

  function automatic int cyc_of(input int ns);
    return (ns + 7) / 8;
  endfunction

  localparam int E_SAMP    = cyc_of(SAMPLE_NS);
  localparam int E_SETUP   = cyc_of(SETUP_NS);
  localparam int E_HOLD    = cyc_of(HOLD_NS);
  localparam int E_INHIBIT = cyc_of(INHIBIT_NS);
  localparam int E_PERIOD  = cyc_of(REFRESH_NS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        code_req;
  logic [4:0]  code_idx;
  logic        code_valid = 1'b0;
  logic [11:0] code_data = '0;
  logic        dac_load;
  logic [11:0] dac_code;
  logic [2:0]  ch_addr;
  logic [3:0]  mode_n;
  logic        busy;

  always #4 clk = ~clk;

  shmux_refresh_seq #(
    .SAMPLE_NS(SAMPLE_NS), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
    .INHIBIT_NS(INHIBIT_NS), .REFRESH_NS(REFRESH_NS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .code_req(code_req), .code_idx(code_idx), .code_valid(code_valid), .code_data(code_data),
    .dac_load(dac_load), .dac_code(dac_code), .ch_addr(ch_addr), .mode_n(mode_n), .busy(busy)
  );

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] code_of(input int ch);
    return 12'((ch * 73 + 11) % 4096);
  endfunction

  // monitor state
  bit  mon_on = 0, long_delay = 0;
  int  cyc = 0, hi_run = 0, lo_run = 0, addr_age = 0, exp_ch = 0, loads = 0;
  int  last_rise = 0, prev_start = 0, starts = 0, samples = 0, req_seen = 0, wcnt = 0;
  bit  prev_hi = 1, prev_req = 0;
  logic [2:0] prev_addr = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit all_hi;
      all_hi = &mode_n;
      cyc++;
      if (code_req) req_seen++;
      if (dac_load) loads++;
      if (code_req && !code_valid) begin
        chk(all_hi, "R4 lines high while stalled", mode_n, 15);
        chk(int'(code_idx) == exp_ch, "R4 pending channel kept", code_idx, exp_ch);
      end
      if (code_req && !prev_req && code_idx == 0) begin
        starts++;
        if (starts > 1) begin
          int e;
          e = prev_start + E_PERIOD;
          if (last_rise + E_HOLD + 1 > e) e = last_rise + E_HOLD + 1;
          chk(cyc == e, "R10 pass start cycle", cyc, e);
        end
        prev_start = cyc;
      end
      if (!all_hi) begin
        chk($countones(~mode_n) == 1, "R5 one line low", $countones(~mode_n), 1);
        chk(busy, "R12 busy while sampling", busy, 1);
        if (prev_hi) begin
          int mux, ch;
          mux = 0;
          for (int i = 0; i < 4; i++) if (!mode_n[i]) mux = i;
          ch = mux * 8 + int'(ch_addr);
          chk(ch == exp_ch, "R2 channel order and mapping", ch, exp_ch);
          chk(dac_code == code_of(exp_ch), "R3 code at sample", dac_code, code_of(exp_ch));
          chk(loads == 1, "R3 one load per channel", loads, 1);
          chk(addr_age >= E_SETUP, "R7 address setup", addr_age, E_SETUP);
          chk(hi_run >= E_INHIBIT, "R9 inhibit window", hi_run, E_INHIBIT);
          loads = 0;
        end
      end else if (!prev_hi) begin
        chk(lo_run == E_SAMP, "R6 sample length", lo_run, E_SAMP);
        exp_ch = (exp_ch + 1) % NCH;
        last_rise = cyc;
        samples++;
      end
      if (ch_addr != prev_addr)
        chk(all_hi && hi_run >= E_HOLD, "R8 address hold", hi_run, E_HOLD);
      if (code_req) chk(busy, "R12 busy while requesting", busy, 1);
      addr_age = (ch_addr == prev_addr) ? addr_age + 1 : 1;
      hi_run   = all_hi ? hi_run + 1 : 0;
      lo_run   = all_hi ? 0 : lo_run + 1;
      prev_addr = ch_addr;
      prev_hi  = all_hi;
      prev_req = code_req;
    end
    // code responder
    if (!code_req) begin
      code_valid = 1'b0;
      wcnt = 0;
    end else if (!code_valid) begin
      if (wcnt >= (long_delay ? 30 : int'(code_idx) % 3)) begin
        code_valid = 1'b1;
        code_data  = code_of(int'(code_idx));
      end else wcnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode_n == 4'hF, "R1 mode lines after reset", mode_n, 15);
    chk(ch_addr == 0, "R1 address after reset", ch_addr, 0);
    chk(!busy && !code_req && !dac_load, "R1 idle outputs", {busy, code_req, dac_load}, 0);
    mon_on = 1;
    repeat (20) @(negedge clk);
    chk(req_seen == 0, "R1 no request while disabled", req_seen, 0);
    enable = 1'b1;
    wait (starts == 3);
    long_delay = 1;                 // this pass overruns the period
    wait (starts == 4);
    long_delay = 0;
    wait (starts == 5);
    s5 = samples;
    @(negedge clk);
    enable = 1'b0;                  // R11 current pass must still finish
    repeat (2 * E_PERIOD) @(negedge clk);
    chk(starts == 5, "R11 no new pass after disable", starts, 5);
    chk(samples - s5 == NCH, "R11 disabled pass completes", samples - s5, NCH);
    chk(!busy, "R11 busy low at end", busy, 0);
    chk(!code_req && mode_n == 4'hF, "R11 idle outputs", {code_req, mode_n}, 15);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule